// File: doc/BRIEF.md
# Wrapping Burst Column Address Generator

This block drives the column side of CPU burst transfers into a DRAM row that is already open. A load strobe captures the starting column, the read/write direction and a wrap-window select. A beat starts on the next clock. During a beat the CAS request and the acknowledge to the CPU are asserted together. When the acknowledge drops, the block checks an active-low burst request. If the request is still asserted, the block steps the column inside the wrap window, waits out a CAS precharge gap and starts the next beat by itself. If the request is not asserted, it returns to the page-held state.

The block runs on a clock at twice the bus rate, so one tick is half a bus clock. Read bursts use a one-tick precharge gap (half a bus clock). Write bursts use a two-tick gap (one bus clock). Only the low column bits inside the window count. The bits above the window keep their starting value, so the column wraps back to the start of its aligned window.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, `cas_o` and `ack_o` are 0 and `col_o` is 0.
- R2: A load pulse while the block is idle sets `col_o` to `col_i`, and `cas_o` and `ack_o` both read 1 on the next clock.
- R3: Each beat holds `cas_o` and `ack_o` high together for exactly ACK_TICKS clocks (default 2), and `col_o` stays steady during the beat.
- R4: When a beat ends with `burst_req_n_i` low (low means a burst is requested), `col_o` advances by one on the edge where the acknowledge falls. The bits above the window keep their value, and the bits inside the window wrap to zero after their maximum.
- R5: The window size is 2 columns for `wrap_sel_i` = 00, 4 for 01, 8 for 10 and 16 for 11.
- R6: After an advance, CAS is reasserted automatically after a low gap. The gap is RD_PRE clocks (default 1) when `rw_i` was 1 (read) at load, and WR_PRE clocks (default 2) when it was 0 (write).
- R7: When a beat ends with `burst_req_n_i` high, no further beat follows and `col_o` keeps the value of that last beat.
- R8: A load pulse that arrives while a beat or a precharge gap is in progress is ignored.
- R9: `rw_i` and `wrap_sel_i` are sampled only at load. Changes to them during a burst do not alter the column order or the gap length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_i | input | 1 | Starts an access with the column on `col_i` |
| col_i | input | COL_W | Starting column |
| wrap_sel_i | input | 2 | Wrap window select (see R5) |
| rw_i | input | 1 | 1 = read, 0 = write |
| burst_req_n_i | input | 1 | Active-low burst request |
| col_o | output | COL_W | Column address to the DRAM |
| cas_o | output | 1 | CAS request |
| ack_o | output | 1 | Transfer acknowledge to the CPU |

## Verification
Two events can land on the same edge. The first is the end of a beat, where the column either advances or holds depending on the burst request. The second is an outside event arriving at that same edge. The bench releases the burst request during the final beat, so the stop decision and the acknowledge fall happen on one edge; it then checks that the column does not move and no extra CAS follows. In other bursts it raises a load pulse and flips the direction and window inputs during a beat. The per-clock reference model then shows that the column sequence and the gap lengths still follow the values captured at load.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_BEAT = 2'd1,
    ST_PRE  = 2'd2
  } beat_state_t;

  localparam int WSEL_W = 2;
  localparam int WIN_W  = 4;

  // Bits of the column that count inside the selected wrap window.
  function automatic logic [WIN_W-1:0] win_mask(input logic [WSEL_W-1:0] sel);
    logic [WIN_W-1:0] m;
    case (sel)
      2'b00:   m = 4'b0001;
      2'b01:   m = 4'b0011;
      2'b10:   m = 4'b0111;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/burst_col_ctr.sv
module burst_col_ctr
  import burst_col_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en_i,
  input  logic                 adv_en_i,
  input  logic [COL_W-1:0]     col_i,
  input  logic [WSEL_W-1:0]    wsel_i,
  output logic [COL_W-1:0]     col_o
);

  localparam int HI_W = COL_W - WIN_W;

  logic [COL_W-1:0]  col_q, col_d;
  logic [WSEL_W-1:0] wsel_q, wsel_d;
  logic [WIN_W-1:0]  lo, lo_inc, mask;
  logic              col_en;

  assign lo     = col_q[WIN_W-1:0];
  assign mask   = win_mask(wsel_q);
  assign lo_inc = lo + {{(WIN_W-1){1'b0}}, 1'b1};
  assign col_en = load_en_i | adv_en_i;

  always_comb begin
    col_d  = col_q;
    wsel_d = wsel_q;
    if (load_en_i) begin
      col_d  = col_i;
      wsel_d = wsel_i;
    end else if (adv_en_i) begin
      col_d = {col_q[COL_W-1:WIN_W], (lo & ~mask) | (lo_inc & mask)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      wsel_q <= '0;
    end else if (col_en) begin
      col_q  <= col_d;
      wsel_q <= wsel_d;
    end
  end

  assign col_o = col_q;

  if (HI_W < 1) begin : g_width_guard
    initial $display("burst_col_ctr: COL_W must exceed the window width");
  end

endmodule

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
  import burst_col_pkg::*;
#(
  parameter int ACK_TICKS = 2,
  parameter int RD_PRE    = 1,
  parameter int WR_PRE    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic rw_i,
  input  logic burst_req_n_i,
  output logic beat_o,
  output logic load_en_o,
  output logic adv_en_o
);

  localparam int MAX_AB = (ACK_TICKS > RD_PRE) ? ACK_TICKS : RD_PRE;
  localparam int MAX_T  = (MAX_AB > WR_PRE) ? MAX_AB : WR_PRE;
  localparam int CNT_W  = (MAX_T < 2) ? 1 : $clog2(MAX_T);
  localparam logic [CNT_W-1:0] ACK_LD = CNT_W'(ACK_TICKS - 1);
  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_PRE - 1);
  localparam logic [CNT_W-1:0] WR_LD  = CNT_W'(WR_PRE - 1);

  beat_state_t      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rd_q, rd_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    rd_d      = rd_q;
    load_en_o = 1'b0;
    adv_en_o  = 1'b0;
    unique case (state_q)
      ST_HOLD: begin
        if (load_i) begin
          load_en_o = 1'b1;
          rd_d      = rw_i;
          cnt_d     = ACK_LD;
          state_d   = ST_BEAT;
        end
      end
      ST_BEAT: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - 1'b1;
        end else if (!burst_req_n_i) begin
          adv_en_o = 1'b1;
          cnt_d    = rd_q ? RD_LD : WR_LD;
          state_d  = ST_PRE;
        end else begin
          state_d = ST_HOLD;
        end
      end
      ST_PRE: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - 1'b1;
        end else begin
          cnt_d   = ACK_LD;
          state_d = ST_BEAT;
        end
      end
      default: state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rd_q    <= rd_d;
    end
  end

  assign beat_o = (state_q == ST_BEAT);

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W     = 11,
  parameter int ACK_TICKS = 2,
  parameter int RD_PRE    = 1,
  parameter int WR_PRE    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       wrap_sel_i,
  input  logic             rw_i,
  input  logic             burst_req_n_i,
  output logic [COL_W-1:0] col_o,
  output logic             cas_o,
  output logic             ack_o
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       beat, load_en, adv_en;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  burst_beat_fsm #(
    .ACK_TICKS (ACK_TICKS),
    .RD_PRE    (RD_PRE),
    .WR_PRE    (WR_PRE)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .load_i        (load_i),
    .rw_i          (rw_i),
    .burst_req_n_i (burst_req_n_i),
    .beat_o        (beat),
    .load_en_o     (load_en),
    .adv_en_o      (adv_en)
  );

  burst_col_ctr #(
    .COL_W (COL_W)
  ) u_ctr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_en_i (load_en),
    .adv_en_i  (adv_en),
    .col_i     (col_i),
    .wsel_i    (wrap_sel_i),
    .col_o     (col_o)
  );

  assign cas_o = beat;
  assign ack_o = beat;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W     = 11,
  parameter int ACK_TICKS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             burst_req_n_i,
  input logic [COL_W-1:0] col_o,
  input logic             cas_o,
  input logic             ack_o
);

  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (!cas_o)     run_q <= '0;
    else if (run_q != 8'hFF) run_q <= run_q + 8'd1;
  end

  // R3: no beat lasts longer than ACK_TICKS clocks
  p_beat_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cas_o |-> (int'(run_q) < ACK_TICKS));

  // R3: column steady while CAS stays high
  p_col_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_o && $past(cas_o)) |-> $stable(col_o));

  // R4: requested burst moves the column, bits above the window untouched
  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_o) && !$past(burst_req_n_i)) |->
      ((col_o != $past(col_o)) && (col_o[COL_W-1:4] == $past(col_o[COL_W-1:4]))));

  // R7: burst released, column holds at the end of the last beat
  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_o) && $past(burst_req_n_i)) |-> $stable(col_o));

endmodule

bind burst_col_gen burst_col_gen_chk #(
  .COL_W     (COL_W),
  .ACK_TICKS (ACK_TICKS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .burst_req_n_i (burst_req_n_i),
  .col_o         (col_o),
  .cas_o         (cas_o),
  .ack_o         (ack_o)
);

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/1ps
module tb_burst_col_gen;

  localparam int COL_W = 11;
  localparam int ACK   = 2;
  localparam int RDP   = 1;
  localparam int WRP   = 2;

  logic             clk, rst_n, load_i, rw_i, burst_req_n_i;
  logic [COL_W-1:0] col_i, col_o;
  logic [1:0]       wrap_sel_i;
  logic             cas_o, ack_o;

  int checks = 0;
  int errors = 0;
  bit chk_on = 0;
  int cyc = 0;

  // reference model state
  int m_phase, m_left, m_col, m_w;
  bit m_rd;

  burst_col_gen #(.COL_W(COL_W), .ACK_TICKS(ACK), .RD_PRE(RDP), .WR_PRE(WRP)) dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .col_i(col_i),
    .wrap_sel_i(wrap_sel_i), .rw_i(rw_i), .burst_req_n_i(burst_req_n_i),
    .col_o(col_o), .cas_o(cas_o), .ack_o(ack_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_col = 0; m_w = 2; m_rd = 0;
    end else if (m_phase == 0) begin
      if (load_i) begin
        m_col = int'(col_i); m_w = 2 << wrap_sel_i; m_rd = rw_i;
        m_phase = 1; m_left = ACK;
      end
    end else if (m_phase == 1) begin
      m_left = m_left - 1;
      if (m_left == 0) begin
        if (!burst_req_n_i) begin
          m_col = m_col - (m_col % m_w) + ((m_col % m_w) + 1) % m_w;
          m_phase = 2; m_left = m_rd ? RDP : WRP;
        end else begin
          m_phase = 0;
        end
      end
    end else begin
      m_left = m_left - 1;
      if (m_left == 0) begin
        m_phase = 1; m_left = ACK;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model (R2 R3 R8 R9)
  always @(negedge clk) begin
    if (chk_on) begin
      check(int'(col_o) == m_col, "R2 R4 R8 R9 column", int'(col_o), m_col);
      check(cas_o == (m_phase == 1), "R3 R6 R7 cas", int'(cas_o), int'(m_phase == 1));
      check(ack_o == (m_phase == 1), "R3 ack", int'(ack_o), int'(m_phase == 1));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_burst(input int start, input int sel, input bit rd,
                           input int nbeats, input bit disturb);
    int got[$];
    int gaps[$];
    int gap = 0, beats = 0, idle = 0, w, base, last;
    bit prev = 0;
    @(negedge clk);
    load_i = 1; col_i = COL_W'(start); wrap_sel_i = 2'(sel); rw_i = rd;
    burst_req_n_i = (nbeats > 1) ? 1'b0 : 1'b1;
    @(negedge clk);
    load_i = 0; col_i = ~COL_W'(start);
    check(cas_o && ack_o && int'(col_o) == start, "R2 load", int'(col_o), start);
    while (idle < 6) begin
      if (cas_o && !prev) begin
        got.push_back(int'(col_o));
        if (beats > 0) gaps.push_back(gap);
        beats++;
        if (beats >= nbeats) burst_req_n_i = 1'b1;
      end
      gap = cas_o ? 0 : gap + 1;
      if (beats >= nbeats && !cas_o) idle++;
      if (disturb && beats == 2 && cas_o) begin
        load_i = 1; col_i = ~COL_W'(start); rw_i = ~rd; wrap_sel_i = ~2'(sel);
      end else begin
        load_i = 0;
      end
      prev = cas_o;
      @(negedge clk);
    end
    w = 2 << sel;
    base = start - (start % w);
    check(beats == nbeats, "R7 beat count", beats, nbeats);
    foreach (got[i]) begin
      int e = base + ((start % w) + i) % w;
      check(got[i] == e, "R4 R5 R9 wrap order", got[i], e);
    end
    foreach (gaps[i])
      check(gaps[i] == (rd ? RDP : WRP), "R6 R9 precharge gap", gaps[i], rd ? RDP : WRP);
    last = got.size() > 0 ? got[got.size()-1] : -1;
    check(int'(col_o) == last, "R7 column held", int'(col_o), last);
  endtask

  initial begin
    rst_n = 1; load_i = 0; col_i = '0; wrap_sel_i = 2'b01; rw_i = 1; burst_req_n_i = 1;
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    check(!cas_o && !ack_o && col_o == '0, "R1 reset", int'({cas_o, ack_o, col_o}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!cas_o && !ack_o && col_o == '0, "R1 idle after reset", int'({cas_o, ack_o, col_o}), 0);
    chk_on = 1;
    run_burst('h0A6, 1, 1'b1, 6, 1'b1);
    run_burst('h3FE, 3, 1'b0, 20, 1'b0);
    run_burst('h155, 0, 1'b1, 3, 1'b0);
    run_burst('h7F3, 2, 1'b0, 9, 1'b1);
    run_burst('h042, 1, 1'b1, 1, 1'b0);
    run_burst('h10F, 3, 1'b1, 4, 1'b0);
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule